// File: doc/BRIEF.md
# Manchester Line Decoder with Preamble Lock

This block turns an oversampled Manchester-coded line into recovered bits. The line is sampled at a fixed multiple of the bit rate, which is eight by default. A two-flop synchronizer comes first, then a minimum-width filter that throws away short noise pulses. A small phase counter takes the place of an analog receive oscillator. While the line is quiet, this counter free-runs against the local sampling clock. It starts to track the line only after a valid training pattern has been seen.

Lock needs the Manchester bit sequence 1, 0, 1, 0. A Manchester 1 is low in the first half of the cell and high in the second half. A Manchester 0 is high in the first half and low in the second. The mid-cell fall of the first 0 freezes the phase counter. The mid-cell fall of the second 0 restarts it, aligned to that edge. Carrier sense rises a quarter bit into the fifth cell. After that, one data-valid strobe is issued per cell, a quarter bit into the following cell. Each strobe carries the level the line had at three quarters of the previous cell. When the line has shown no transition for one and a half bit times, the decoder drops carrier, holds the data output high and waits for a new training pattern.

Top module: `manch_rx`

## Requirements
- R1: A line pulse shorter than MIN_W samples (default 2, a quarter bit) is ignored. In idle it never starts carrier. Placed at the three-quarter point of a data cell, it does not change the decoded bit.
- R2: Carrier is raised only after the Manchester sequence 1,0,1,0 (1 = low then high, 0 = high then low, with mid-cell transitions 8 samples apart). A run of 1s, a run of 0s, or 1,0,1 followed by a steady line gives no carrier and no strobe. An extra leading 1 before 1,0,1,0 still locks on the 1,0,1,0.
- R3: Let edge k be the rising clock edge that first captures the line sample after the bit-4 mid-cell fall. Carrier goes high at edge k+10: a quarter bit into cell 5, plus the 4-clock input path.
- R4: The first data-valid strobe is registered at edge k+18, a quarter bit into cell 6. It carries bit 5, the first bit after the training pattern.
- R5: Every bit after the training pattern gives exactly one strobe. Strobes are 8 clocks apart. rx_bit equals the level in the second half of the cell, where high is 1.
- R6: rx_valid lasts one clock and is high only while carrier is high.
- R7: rx_bit is high whenever carrier is low, including straight after reset.
- R8: Let edge L be the edge that captures the last line transition. Carrier falls at edge L+17, which is 12 clocks of silence after the input path. No strobe follows the one for the last bit.
- R9: rx_bit changes only on a clock where rx_valid rises or carrier falls.
- R10: After carrier drops, a later frame locks and decodes in the same way as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, OSR times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Sampled Manchester line bit |
| rx_bit | output | 1 | Recovered NRZ data, high while idle |
| rx_valid | output | 1 | One-clock strobe marking a new rx_bit |
| carrier | output | 1 | Carrier sense: high from lock until the line goes silent |

## Verification
On every clock, the embedded properties check several rules. Strobes are single pulses and appear only under carrier. The data output stays high whenever carrier is off, and it moves only with a strobe or a carrier drop. Carrier falls only after the full silence interval. The filtered line level changes only after the synchronized input has held its new value for the minimum width. The bench scenarios are the only place where lock selectivity against the wrong patterns can be shown. They also check the exact edges at which carrier rises and falls, the placement of the first strobe, and the decoded bit values for random data, with and without injected noise pulses.

// File: rtl/manch_rx.sv
module manch_rx #(
  parameter int OSR   = 8,
  parameter int MIN_W = 2,
  parameter int TOL   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic rx_bit,
  output logic rx_valid,
  output logic carrier
);
  localparam int PW     = $clog2(OSR);
  localparam int SIL    = OSR + OSR / 2;
  localparam int CW     = $clog2(SIL + 1);
  localparam int FW     = $clog2(MIN_W + 1);
  localparam int PH_SMP = OSR / 4;
  localparam int PH_STB = OSR / 2 + OSR / 4;
  localparam int GAP_LO = OSR - 1 - TOL;
  localparam int GAP_HI = OSR - 1 + TOL;

  typedef enum logic [1:0] {IDLE, ACQ, LOCK} st_t;

  st_t           st;
  logic          s1, s2, lvl, lvl_q, smp;
  logic [FW-1:0] fcnt;
  logic [PW-1:0] ph;
  logic [CW-1:0] gap;
  logic [1:0]    step;

  wire          tr     = lvl ^ lvl_q;
  wire          in_win = (gap >= CW'(GAP_LO)) && (gap <= CW'(GAP_HI));
  wire [PW-1:0] ph_inc = (ph == PW'(OSR - 1)) ? '0 : ph + 1'b1;
  wire          near_mid = (ph == PW'(OSR - 1)) || (ph == '0) || (ph == PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0; s2 <= 1'b0; lvl <= 1'b0; lvl_q <= 1'b0; fcnt <= '0;
    end else begin
      s1    <= line_in;
      s2    <= s1;
      lvl_q <= lvl;
      if (s2 == lvl) fcnt <= '0;
      else if (fcnt == FW'(MIN_W - 1)) begin
        lvl  <= s2;
        fcnt <= '0;
      end else fcnt <= fcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= IDLE; step <= '0; ph <= '0; gap <= '0; smp <= 1'b1;
      rx_bit <= 1'b1; rx_valid <= 1'b0; carrier <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      gap <= tr ? '0 : ((gap == CW'(SIL)) ? gap : gap + 1'b1);
      case (st)
        IDLE: begin
          ph      <= ph_inc;
          rx_bit  <= 1'b1;
          carrier <= 1'b0;
          if (tr && lvl) begin
            st   <= ACQ;
            step <= '0;
          end
        end
        ACQ: begin
          if (step == '0) ph <= ph_inc;
          if (tr) begin
            if (in_win && (lvl == step[0])) begin
              if (step == 2'd2) begin
                st <= LOCK;
                ph <= PW'(1);
              end else step <= step + 1'b1;
            end else if (lvl) step <= '0;
            else st <= IDLE;
          end else if (gap > CW'(GAP_HI)) st <= IDLE;
        end
        default: begin
          ph <= (tr && near_mid) ? PW'(1) : ph_inc;
          if (ph == PW'(PH_SMP)) smp <= lvl;
          if (ph == PW'(PH_STB)) begin
            if (carrier) begin
              rx_valid <= 1'b1;
              rx_bit   <= smp;
            end
            carrier <= 1'b1;
          end
          if (!tr && gap == CW'(SIL)) begin
            st       <= IDLE;
            carrier  <= 1'b0;
            rx_bit   <= 1'b1;
            rx_valid <= 1'b0;
          end
        end
      endcase
    end
  end

  // R6
  valid_needs_carrier_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> carrier);
  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !carrier |-> rx_bit);
  // R9
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_bit) |-> (rx_valid || $fell(carrier)));
  // R8
  silence_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(carrier) |-> ($past(gap) == CW'(SIL)));

  generate
    if (MIN_W >= 2) begin : g_flt_chk
      // R1
      min_width_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl != $past(lvl)) |-> (($past(s2) == lvl) && ($past(s2, 2) == lvl)));
    end
  endgenerate
endmodule

// File: tb/sim_manch_rx.sv
module sim_manch_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_in = 1'b0;
  logic rx_bit, rx_valid, carrier;

  always #2.5 clk = ~clk;

  manch_rx u0 (
    .clk(clk), .rst(rst), .line_in(line_in),
    .rx_bit(rx_bit), .rx_valid(rx_valid), .carrier(carrier)
  );

  int tick = 0;
  always @(posedge clk) tick <= tick + 1;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int v_t[$];
  bit v_b[$];
  int rise_t = 0, fall_t = 0, rise_n = 0;
  int r6_bad = 0, r7_bad = 0, r9_bad = 0;
  bit car_q = 1'b0, bit_q = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        v_t.push_back(tick);
        v_b.push_back(rx_bit);
        if (!carrier) r6_bad++;
      end
      if (!carrier && !rx_bit) r7_bad++;
      if ((rx_bit != bit_q) && !rx_valid && !(car_q && !carrier)) r9_bad++;
      if (carrier && !car_q) begin rise_t = tick; rise_n++; end
      if (!carrier && car_q) fall_t = tick;
      car_q = carrier;
      bit_q = rx_bit;
    end
  end

  function automatic int exp_rise(int k);  return k + 11; endfunction
  function automatic int exp_first(int k); return k + 19; endfunction
  function automatic int exp_fall(int l);  return l + 18; endfunction
  function automatic bit cell_level(bit b, int s); return (s < 4) ? !b : b; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int last_edge = 0, k4 = 0;

  task automatic put(bit v);
    @(negedge clk);
    if (v != line_in) last_edge = tick;
    line_in = v;
  endtask

  task automatic hold(int n);
    repeat (n) put(line_in);
  endtask

  task automatic send_bit(bit b, bit glitch, bit mark);
    for (int s = 0; s < 8; s++) begin
      bit v = cell_level(b, s);
      if (glitch && s == 6) v = !v;
      put(v);
      if (mark && s == 4) k4 = tick;
    end
  endtask

  task automatic clear_mon();
    v_t.delete();
    v_b.delete();
    rise_n = 0;
  endtask

  task automatic no_lock(string what);
    hold(30);
    chk(rise_n == 0, what, rise_n, 0);
    chk(v_t.size() == 0, what, v_t.size(), 0);
  endtask

  task automatic frame(int nd, bit pre1, bit noisy, string rtag);
    bit exp_q[$];
    int le, bad, gap_bad;
    clear_mon();
    if (pre1) send_bit(1'b1, 1'b0, 1'b0);
    send_bit(1'b1, 1'b0, 1'b0);
    send_bit(1'b0, 1'b0, 1'b0);
    send_bit(1'b1, 1'b0, 1'b0);
    send_bit(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < nd; i++) begin
      bit b = 1'($urandom % 2);
      bit g = noisy && (i != nd - 1) && ($urandom % 3 == 0);
      exp_q.push_back(b);
      send_bit(b, g, 1'b0);
    end
    le = last_edge;
    hold(30);
    chk(rise_n == 1, rtag, rise_n, 1);
    chk(rise_t == exp_rise(k4), "R3 carrier rise", rise_t, exp_rise(k4));
    chk(v_t.size() == nd, "R5 strobe count", v_t.size(), nd);
    if (v_t.size() > 0) begin
      chk(v_t[0] == exp_first(k4), "R4 first strobe time", v_t[0], exp_first(k4));
      chk(v_b[0] == exp_q[0], "R4 first bit", v_b[0], exp_q[0]);
    end
    bad = 0;
    gap_bad = 0;
    for (int i = 0; i < v_t.size() && i < nd; i++) begin
      if (v_b[i] != exp_q[i]) bad++;
      if (i > 0 && v_t[i] - v_t[i-1] != 8) gap_bad++;
    end
    chk(bad == 0, noisy ? "R1 bits under noise" : "R5 bits", bad, 0);
    chk(gap_bad == 0, "R5 strobe spacing", gap_bad, 0);
    chk(fall_t == exp_fall(le), "R8 carrier fall", fall_t, exp_fall(le));
    chk(rx_bit == 1'b1 && carrier == 1'b0, "R7 idle after frame", rx_bit, 1);
  endtask

  initial begin
    #750000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", tick, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(carrier == 1'b0, "R7 reset carrier", carrier, 0);
    chk(rx_valid == 1'b0, "R6 reset strobe", rx_valid, 0);
    chk(rx_bit == 1'b1, "R7 reset data high", rx_bit, 1);

    clear_mon();
    hold(10);
    repeat (8) begin
      put(1'b1);
      repeat (6) put(1'b0);
    end
    no_lock("R1 idle pulses");

    clear_mon();
    repeat (10) send_bit(1'b1, 1'b0, 1'b0);
    no_lock("R2 all ones");

    clear_mon();
    repeat (10) send_bit(1'b0, 1'b0, 1'b0);
    no_lock("R2 all zeros");

    clear_mon();
    send_bit(1'b1, 1'b0, 1'b0);
    send_bit(1'b0, 1'b0, 1'b0);
    send_bit(1'b1, 1'b0, 1'b0);
    no_lock("R2 short pattern");

    frame(12, 1'b0, 1'b0, "R2 lock on 1010");
    frame(20, 1'b1, 1'b0, "R10 relock with extra leading 1");
    frame(16, 1'b0, 1'b1, "R10 relock noisy");
    repeat (5) frame(4 + int'($urandom % 28), 1'($urandom % 2), 1'($urandom % 2), "R10 random frame");

    chk(r6_bad == 0, "R6 strobe without carrier", r6_bad, 0);
    chk(r7_bad == 0, "R7 data low without carrier", r7_bad, 0);
    chk(r9_bad == 0, "R9 data moved without strobe", r9_bad, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule